// File: doc/BRIEF.md
# Flash sector-erase command sequencer

This block sits behind the bus-write decoder of a flash-style device. Each cycle it may receive one write event: an address and a data byte. It tracks a six-write software command sequence. Two unlock writes come first. A setup write follows, then the unlock pair again, then a final write that names the sector. When the sixth write arrives in the expected order, the block issues a one-cycle erase-start pulse and latches the sector number taken from that write's address.

A write that breaks the sequence sends the tracker back to the beginning. If that breaking write is itself the first unlock write, it counts as a fresh first step. Writes whose upper address bits fall outside the device's mapped window are not meant for this device and are not seen at all. After an erase start, a busy flag stays high for a programmable number of clocks to model the erase time, and writes that arrive during that time are dropped. A synchronous clear input returns the tracker to its idle step and drops busy at once. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `erase_cmd_seq`

## Requirements
- R1: While reset is applied and afterwards until the first accepted write, `erase_start` and `busy` are 0 and `erase_sector` is 0.
- R2: Six accepted writes in this order produce `erase_start` high for exactly one cycle, in the cycle after the sixth write is sampled: AAh at low address 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 30h. Here "low address" means `wr_addr[15:0]`.
- R3: `erase_sector` takes `wr_addr[ARRAY_BITS-1:SECTOR_BITS]` of the sixth write (bits 18:12 by default) in the same cycle that `erase_start` rises, and holds that value until the next erase start.
- R4: For the five unlock and setup writes, address bits `[ARRAY_BITS-1:16]` have no effect on matching. For the sixth write, bits below `SECTOR_BITS` have no effect.
- R5: A write whose bits `wr_addr[ADDR_W-1:ARRAY_BITS]` differ from `MAP_TAG` (all ones by default) is ignored: the sequence step does not change.
- R6: An in-range write that does not match the current step, and is not AAh at 5555h, returns the sequencer to its idle step.
- R7: A mismatching in-range write that is AAh at 5555h leaves the sequencer with step 1 completed.
- R8: `busy` rises together with `erase_start` and stays high for exactly `BUSY_CYCLES` cycles.
- R9: Writes sampled while `busy` is high are ignored and never advance the sequence.
- R10: `seq_clr` sampled high returns the sequencer to idle and clears `busy` in the next cycle. It takes priority over a write in the same cycle.
- R11: Address and data values on cycles with `wr_valid` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_clr | input | 1 | Synchronous clear of the sequence and busy |
| wr_valid | input | 1 | A write event is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| erase_start | output | 1 | One-cycle pulse that starts a sector erase |
| erase_sector | output | ARRAY_BITS-SECTOR_BITS | Sector of the last erase start |
| busy | output | 1 | Erase in progress; writes are dropped |

## Verification
A behavioural reference model runs alongside the block and is compared with its outputs on every clock. The stimulus covers:
- a clean six-write sequence, to show that the pulse, the sector number and the busy length are right;
- unlock writes with noise in the don't-care address bits, to separate true low-address decoding from full-address matching;
- out-of-range writes, wrong writes and stray AAh-at-5555h writes placed mid-sequence, to tell "ignore", "restart to idle" and "restart as step 1" apart;
- sequences sent during busy, sequences cut by `seq_clr`, and data left on the bus with `wr_valid` low, to show that none of these moves the sequencer.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_U1    = 3'd1,
    ST_U2    = 3'd2,
    ST_SETUP = 3'd3,
    ST_U3    = 3'd4,
    ST_U4    = 3'd5
  } step_e;

  localparam logic [15:0] LO_ADDR_A  = 16'h5555;
  localparam logic [15:0] LO_ADDR_B  = 16'h2AAA;
  localparam logic [7:0]  BYTE_KEY_A = 8'hAA;
  localparam logic [7:0]  BYTE_KEY_B = 8'h55;
  localparam logic [7:0]  BYTE_SETUP = 8'h80;
  localparam logic [7:0]  BYTE_ERASE = 8'h30;

  typedef struct packed {
    logic in_range;
    logic hit_key_a;
    logic hit_key_b;
    logic hit_setup;
    logic hit_erase;
  } wr_class_t;

endpackage

// File: rtl/erase_cmd_match.sv
module erase_cmd_match
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ARRAY_BITS = 19,
  parameter logic [ADDR_W-ARRAY_BITS-1:0] MAP_TAG = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output wr_class_t         cls_o
);

  logic [15:0] lo_addr;
  logic        lo_is_a;
  logic        lo_is_b;

  always_comb begin
    lo_addr = addr_i[15:0];
    lo_is_a = (lo_addr == LO_ADDR_A);
    lo_is_b = (lo_addr == LO_ADDR_B);
    cls_o.in_range  = (addr_i[ADDR_W-1:ARRAY_BITS] == MAP_TAG);
    cls_o.hit_key_a = lo_is_a && (data_i == BYTE_KEY_A);
    cls_o.hit_key_b = lo_is_b && (data_i == BYTE_KEY_B);
    cls_o.hit_setup = lo_is_a && (data_i == BYTE_SETUP);
    cls_o.hit_erase = (data_i == BYTE_ERASE);
  end

endmodule

// File: rtl/erase_step_fsm.sv
module erase_step_fsm
  import erase_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      wr_en_i,
  input  wr_class_t cls_i,
  output logic      fire_o
);

  step_e step_q;
  step_e step_d;
  step_e restart;

  always_comb begin
    restart = cls_i.hit_key_a ? ST_U1 : ST_IDLE;
    step_d  = step_q;
    fire_o  = 1'b0;
    if (clr_i) begin
      step_d = ST_IDLE;
    end else if (wr_en_i) begin
      unique case (step_q)
        ST_IDLE:  step_d = cls_i.hit_key_a ? ST_U1 : ST_IDLE;
        ST_U1:    step_d = cls_i.hit_key_b ? ST_U2 : restart;
        ST_U2:    step_d = cls_i.hit_setup ? ST_SETUP : restart;
        ST_SETUP: step_d = cls_i.hit_key_a ? ST_U3 : restart;
        ST_U3:    step_d = cls_i.hit_key_b ? ST_U4 : restart;
        ST_U4: begin
          if (cls_i.hit_erase) begin
            step_d = ST_IDLE;
            fire_o = 1'b1;
          end else begin
            step_d = restart;
          end
        end
        default:  step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  // R10: clear wins and lands in idle
  p_clr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> step_q == ST_IDLE);
  // R9 / R5 / R11: no enabled write, no movement
  p_hold_idle_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !clr_i) |=> $stable(step_q));
  // R2: an erase start always leaves the sequence idle
  p_fire_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> step_q == ST_IDLE);
  // R7: a mismatching first-unlock write leaves step 1 done
  p_restart_step1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i && cls_i.hit_key_a && step_q != ST_SETUP) |=> step_q == ST_U1);

endmodule

// File: rtl/erase_busy_timer.sv
module erase_busy_timer #(
  parameter int BUSY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic load_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || load_i || (cnt_q != '0);
    if (clr_i)        cnt_d = '0;
    else if (load_i)  cnt_d = CNT_W'(BUSY_CYCLES);
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R9: a new erase can only be launched when idle
  p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);
  // R10: clear drops busy next cycle
  p_clr_drops_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !busy_o);
  // R8: busy only appears through a load
  p_busy_from_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(load_i));

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ARRAY_BITS  = 19,
  parameter int SECTOR_BITS = 12,
  parameter int BUSY_CYCLES = 20,
  parameter logic [ADDR_W-ARRAY_BITS-1:0] MAP_TAG = '1,
  localparam int SECT_W = ARRAY_BITS - SECTOR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              erase_start,
  output logic [SECT_W-1:0] erase_sector,
  output logic              busy
);

  logic              rst_meta;
  logic              rst_ni;
  wr_class_t         cls;
  logic              wr_en;
  logic              fire;
  logic              start_q;
  logic [SECT_W-1:0] sector_q;
  logic [SECT_W-1:0] sector_d;
  logic              start_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  erase_cmd_match #(
    .ADDR_W    (ADDR_W),
    .ARRAY_BITS(ARRAY_BITS),
    .MAP_TAG   (MAP_TAG)
  ) u_match (
    .addr_i(wr_addr),
    .data_i(wr_data),
    .cls_o (cls)
  );

  assign wr_en = wr_valid && cls.in_range && !busy;

  erase_step_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr_i  (seq_clr),
    .wr_en_i(wr_en),
    .cls_i  (cls),
    .fire_o (fire)
  );

  erase_busy_timer #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr_i (seq_clr),
    .load_i(fire),
    .busy_o(busy)
  );

  always_comb begin
    start_d  = fire;
    sector_d = fire ? wr_addr[ARRAY_BITS-1:SECTOR_BITS] : sector_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      sector_q <= '0;
    end else begin
      start_q  <= start_d;
      sector_q <= sector_d;
    end
  end

  assign erase_start  = start_q;
  assign erase_sector = sector_q;

  // R2: the start pulse lasts a single cycle
  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    erase_start |=> !erase_start);
  // R8: busy accompanies the pulse
  p_busy_with_start_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    erase_start |-> busy);
  // R3: sector only changes with a start
  p_sector_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !erase_start |-> $stable(erase_sector));

endmodule

// File: tb/erase_cmd_seq_tb.sv
module erase_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_clr = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        erase_start;
  logic [6:0]  erase_sector;
  logic        busy;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    n_pulses = 0;

  // reference model state
  int       m_step = 0;
  int       m_cnt = 0;
  bit       m_start = 0;
  bit [6:0] m_sector = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_cmd_seq #(.BUSY_CYCLES(BUSY_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_start(erase_start), .erase_sector(erase_sector), .busy(busy)
  );

  function automatic bit step_ok(int s, logic [31:0] a, logic [7:0] d);
    case (s)
      0, 3:    return d == 8'hAA && a[15:0] == 16'h5555;
      1, 4:    return d == 8'h55 && a[15:0] == 16'h2AAA;
      2:       return d == 8'h80 && a[15:0] == 16'h5555;
      default: return d == 8'h30;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_cnt = 0; m_start = 0; m_sector = '0;
    end else begin
      bit take;
      m_start = 0;
      if (seq_clr) begin
        m_step = 0; m_cnt = 0;
      end else begin
        take = wr_valid && (wr_addr[31:19] == 13'h1FFF) && (m_cnt == 0);
        if (m_cnt > 0) m_cnt--;
        if (take) begin
          if (step_ok(m_step, wr_addr, wr_data)) begin
            if (m_step == 5) begin
              m_step = 0; m_start = 1; m_cnt = BUSY_N;
              m_sector = wr_addr[18:12];
            end else m_step++;
          end else begin
            m_step = (wr_data == 8'hAA && wr_addr[15:0] == 16'h5555) ? 1 : 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (erase_start !== m_start || busy !== (m_cnt != 0) || erase_sector !== m_sector) begin
      n_fail++;
      $display("FAIL %s: start=%b busy=%b sector=%h, expected start=%b busy=%b sector=%h",
               cur_req, erase_start, busy, erase_sector, m_start, (m_cnt != 0), m_sector);
    end
    if (erase_start === 1'b1) n_pulses++;
  end

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock5(input logic [31:0] hi);
    wr(hi | 32'h5555, 8'hAA);
    wr(hi | 32'h2AAA, 8'h55);
    wr(hi | 32'h5555, 8'h80);
    wr(hi | 32'h5555, 8'hAA);
    wr(hi | 32'h2AAA, 8'h55);
  endtask

  task automatic expect_pulses(input int exp, input string req);
    n_checks++;
    if (n_pulses != exp) begin
      n_fail++;
      $display("FAIL %s: pulses=%0d expected=%0d", req, n_pulses, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: cycles=50000 expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(5);
    expect_pulses(0, "R1");

    cur_req = "R2";
    unlock5(32'hFFF8_0000);
    wr(32'hFFFA_A345, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(1, "R2");

    cur_req = "R3";
    unlock5(32'hFFF8_0000);
    wr(32'hFFFF_FFFF, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(2, "R3");

    cur_req = "R4";
    wr(32'hFFFD_5555, 8'hAA);
    wr(32'hFFFB_2AAA, 8'h55);
    wr(32'hFFFE_5555, 8'h80);
    wr(32'hFFF9_5555, 8'hAA);
    wr(32'hFFFF_2AAA, 8'h55);
    wr(32'hFFF8_1ABC, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(3, "R4");

    cur_req = "R5";
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'h0000_1234, 8'h00);
    wr(32'h7FF8_5555, 8'h11);
    wr(32'hFFF8_5555, 8'h80);
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_3000, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(4, "R5");

    cur_req = "R6";
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_5555, 8'h81);
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_4000, 8'h30);
    idle(4);
    expect_pulses(4, "R6");

    cur_req = "R7";
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_5555, 8'h80);
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_5000, 8'h30);
    idle(2);
    expect_pulses(5, "R7");

    cur_req = "R9";
    unlock5(32'hFFF8_0000);
    wr(32'hFFF8_6000, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(5, "R9");

    cur_req = "R8";
    unlock5(32'hFFF8_0000);
    wr(32'hFFF8_7000, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(6, "R8");

    cur_req = "R10";
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_5555, 8'h80);
    @(negedge clk); seq_clr = 1'b1;
    wr_valid = 1'b1; wr_addr = 32'hFFF8_5555; wr_data = 8'hAA;
    @(negedge clk); seq_clr = 1'b0; wr_valid = 1'b0;
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_8000, 8'h30);
    idle(3);
    expect_pulses(6, "R10");
    unlock5(32'hFFF8_0000);
    wr(32'hFFF8_9000, 8'h30);
    idle(4);
    @(negedge clk); seq_clr = 1'b1;
    @(negedge clk); seq_clr = 1'b0;
    idle(2);
    expect_pulses(7, "R10");

    cur_req = "R11";
    wr(32'hFFF8_5555, 8'hAA);
    @(negedge clk); wr_addr = 32'hFFF8_1111; wr_data = 8'h77;
    idle(3);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_5555, 8'h80);
    @(negedge clk); wr_addr = 32'hFFF8_0000; wr_data = 8'hFF;
    idle(2);
    wr(32'hFFF8_5555, 8'hAA);
    wr(32'hFFF8_2AAA, 8'h55);
    wr(32'hFFF8_A000, 8'h30);
    idle(BUSY_N + 3);
    expect_pulses(8, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule